// File: doc/BRIEF.md
# Register-Mapped Serial Port with Receive FIFO

This peripheral gives a processor a byte-wide serial channel through a small bank of 32-bit registers. The registers sit on a word-addressed bus that only makes full-word accesses. Received bytes come in over a valid/ready byte interface and collect in a circular FIFO. One status/data word reports the oldest byte together with a data-available flag. That word is reachable at two addresses: reading one address leaves the FIFO untouched, and reading the other consumes the byte.

Writing the data-out register sends its low byte as a one-cycle strobe on the transmit output. The same write raises two transmit interrupt bits. A raw interrupt register collects these transmit events and a receive-not-empty bit. A mask register selects which raw bits drive the single level interrupt line, and a masked view of the raw bits can be read back. Interrupts are cleared by writing an acknowledge register.

The acknowledge register has one deliberate quirk. The first acknowledge after a transmit cannot clear bit 0, so software that clears everything at once still sees the transmit-ready event once more.

Top module: `ser_port`

## Requirements
- R1: After reset, the receive control register (byte offset 0x08) reads 0x00010000, so receive enable (bit 3) is off. Every other register reads 0, the FIFO is empty, `irq` is low, `rxReady` is low and `txValid` is low.
- R2: A read of the status/data word at offset 0x20 or 0x24 returns:
  - the oldest FIFO byte in bits 7:0;
  - bit 16 = 1 exactly when the FIFO holds at least one byte;
  - bits 22 and 24 always 1;
  - all other bits 0.
- R3: A read at offset 0x24 never changes the FIFO. A read at offset 0x20 removes the oldest byte when the FIFO is non-empty. A read at 0x20 on an empty FIFO has no effect.
- R4: The FIFO holds up to FIFO_DEPTH (default 16) bytes and returns them in arrival order, including across pointer wrap. A byte offered while the FIFO is full is not stored.
- R5: `rxReady` is high exactly when receive-control bit 3 is set and the FIFO is not full. A byte is taken only in a cycle where `rxValid` and `rxReady` are both high. Bytes offered while `rxReady` is low are discarded.
- R6: Raw interrupt bit 3 (offset 0x34) is 1 exactly while the FIFO is non-empty. Acknowledging bit 3 does not clear it while bytes remain.
- R7: A write to offset 0x1C does three things:
  - it raises `txValid` for exactly one cycle, starting the cycle after the write, with `txByte` equal to the low byte of the written word;
  - it stores the full word, which reads back at 0x1C;
  - it sets raw interrupt bits 0 and 1.
- R8: A write to the acknowledge register (offset 0x30) is handled as follows:
  - If a transmit has happened since the last acknowledge, bit 0 of the written value is forced to 0 and that pending condition ends.
  - The adjusted value is stored and reads back at 0x30.
  - Each raw interrupt bit that is 1 in the adjusted value is cleared.
- R9: The masked register (offset 0x38) reads raw AND mask (mask at offset 0x2C). `irq` is high whenever that value is non-zero.
- R10: Writes to offsets 0x20, 0x24, 0x34 and 0x38 change nothing; in particular, a write to 0x20 does not remove a byte. Offsets 0x00 and 0x04 are plain read/write storage. Reads of undecoded offsets (such as 0x0C, 0x28, 0x3C) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address; bits 1:0 are ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | Received byte offered |
| rxReady | output | 1 | Receiver can take a byte |
| txByte | output | 8 | Transmitted byte |
| txValid | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default FIFO_DEPTH of 16. At that depth, a full fill followed by a full drain is a short run, and the bench does this after the pointers have already moved, so wrap-around and the discard of a byte offered to a full FIFO are both reached. Both transmit-acknowledge paths are driven in sequence, the quirked first write and the plain second one. The peek and pop addresses are read against the same FIFO contents.

// File: rtl/serp_pkg.sv
package serp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 6;

  localparam logic [3:0] IDX_TXCTRL = 4'h0;
  localparam logic [3:0] IDX_DMAEN  = 4'h1;
  localparam logic [3:0] IDX_RXCTRL = 4'h2;
  localparam logic [3:0] IDX_DOUT   = 4'h7;
  localparam logic [3:0] IDX_POP    = 4'h8;
  localparam logic [3:0] IDX_PEEK   = 4'h9;
  localparam logic [3:0] IDX_MASK   = 4'hB;
  localparam logic [3:0] IDX_ACK    = 4'hC;
  localparam logic [3:0] IDX_RAW    = 4'hD;
  localparam logic [3:0] IDX_MASKED = 4'hE;

  localparam int unsigned BIT_RXEN  = 3;
  localparam logic [WORD_W-1:0] RXCTRL_RST = 32'h0001_0000;

  typedef enum logic [3:0] {
    RD_ZERO, RD_TXCTRL, RD_DMAEN, RD_RXCTRL, RD_DOUT,
    RD_STATUS, RD_MASK, RD_ACK, RD_RAW, RD_MASKED
  } rdSel_e;

  typedef struct packed {
    logic   wrTxCtrl;
    logic   wrDmaEn;
    logic   wrRxCtrl;
    logic   wrDout;
    logic   wrMask;
    logic   wrAck;
    logic   rdPop;
    rdSel_e rdSel;
  } busStrobe_t;
endpackage

// File: rtl/ser_busdec.sv
module ser_busdec
  import serp_pkg::*;
(
  input  logic       busSel,
  input  logic       busWe,
  input  logic [3:0] wordIdx,
  output busStrobe_t strb
);
  logic doWr;
  logic doRd;

  assign doWr = busSel & busWe;
  assign doRd = busSel & ~busWe;

  always_comb begin
    strb          = '0;
    strb.rdSel    = RD_ZERO;
    strb.wrTxCtrl = doWr && (wordIdx == IDX_TXCTRL);
    strb.wrDmaEn  = doWr && (wordIdx == IDX_DMAEN);
    strb.wrRxCtrl = doWr && (wordIdx == IDX_RXCTRL);
    strb.wrDout   = doWr && (wordIdx == IDX_DOUT);
    strb.wrMask   = doWr && (wordIdx == IDX_MASK);
    strb.wrAck    = doWr && (wordIdx == IDX_ACK);
    strb.rdPop    = doRd && (wordIdx == IDX_POP);
    case (wordIdx)
      IDX_TXCTRL: strb.rdSel = RD_TXCTRL;
      IDX_DMAEN:  strb.rdSel = RD_DMAEN;
      IDX_RXCTRL: strb.rdSel = RD_RXCTRL;
      IDX_DOUT:   strb.rdSel = RD_DOUT;
      IDX_POP,
      IDX_PEEK:   strb.rdSel = RD_STATUS;
      IDX_MASK:   strb.rdSel = RD_MASK;
      IDX_ACK:    strb.rdSel = RD_ACK;
      IDX_RAW:    strb.rdSel = RD_RAW;
      IDX_MASKED: strb.rdSel = RD_MASKED;
      default:    strb.rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/ser_rxfifo.sv
module ser_rxfifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             doPush;
  logic             doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ser_dp.sv
module ser_dp
  import serp_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [7:0]        rxByte,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [7:0]        txByte,
  output logic              txValid,
  output logic              irq,
  output logic [CNT_W-1:0]  rxCount,
  output logic [WORD_W-1:0] maskOut
);
  logic [WORD_W-1:0] txCtrlQ, dmaEnQ, rxCtrlQ, doutQ, maskQ, ackQ;
  logic [1:0]        rawTxQ;
  logic              pendTxQ;
  logic [7:0]        txByteQ;
  logic              txValidQ;

  logic [7:0]        fifoHead;
  logic              fifoFull;
  logic              fifoEmpty;
  logic [WORD_W-1:0] rawView;
  logic [WORD_W-1:0] maskedView;
  logic [WORD_W-1:0] statusWord;
  logic [WORD_W-1:0] ackAdj;

  assign rxReady = rxCtrlQ[BIT_RXEN] & ~fifoFull;

  ser_rxfifo #(.DEPTH(DEPTH), .W(8)) uFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (rxValid & rxReady),
    .pushData (rxByte),
    .pop      (strb.rdPop),
    .head     (fifoHead),
    .count    (rxCount),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  assign rawView    = {28'b0, ~fifoEmpty, 1'b0, rawTxQ};
  assign maskedView = rawView & maskQ;
  assign irq        = |maskedView;
  assign statusWord = {7'b0, 1'b1, 1'b0, 1'b1, 5'b0, ~fifoEmpty, 8'b0, fifoHead};
  assign ackAdj     = pendTxQ ? (wdata & ~32'h1) : wdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCtrlQ  <= '0;
      dmaEnQ   <= '0;
      rxCtrlQ  <= RXCTRL_RST;
      doutQ    <= '0;
      maskQ    <= '0;
      ackQ     <= '0;
      rawTxQ   <= '0;
      pendTxQ  <= 1'b0;
      txByteQ  <= '0;
      txValidQ <= 1'b0;
    end else begin
      txValidQ <= strb.wrDout;
      if (strb.wrTxCtrl) txCtrlQ <= wdata;
      if (strb.wrDmaEn)  dmaEnQ  <= wdata;
      if (strb.wrRxCtrl) rxCtrlQ <= wdata;
      if (strb.wrMask)   maskQ   <= wdata;
      if (strb.wrDout) begin
        doutQ   <= wdata;
        txByteQ <= wdata[7:0];
        rawTxQ  <= 2'b11;
        pendTxQ <= 1'b1;
      end else if (strb.wrAck) begin
        ackQ    <= ackAdj;
        rawTxQ  <= rawTxQ & ~ackAdj[1:0];
        pendTxQ <= 1'b0;
      end
    end
  end

  assign txByte  = txByteQ;
  assign txValid = txValidQ;
  assign maskOut = maskQ;

  always_comb begin
    case (strb.rdSel)
      RD_TXCTRL: rdata = txCtrlQ;
      RD_DMAEN:  rdata = dmaEnQ;
      RD_RXCTRL: rdata = rxCtrlQ;
      RD_DOUT:   rdata = doutQ;
      RD_STATUS: rdata = statusWord;
      RD_MASK:   rdata = maskQ;
      RD_ACK:    rdata = ackQ;
      RD_RAW:    rdata = rawView;
      RD_MASKED: rdata = maskedView;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/ser_port.sv
module ser_port
  import serp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [WORD_W-1:0]  busWdata,
  output logic [WORD_W-1:0]  busRdata,
  input  logic [7:0]         rxByte,
  input  logic               rxValid,
  output logic               rxReady,
  output logic [7:0]         txByte,
  output logic               txValid,
  output logic               irq
);
  busStrobe_t        strb;
  logic [CNT_W-1:0]  rxCount;
  logic [WORD_W-1:0] maskQ;

  ser_busdec uDec (
    .busSel  (busSel),
    .busWe   (busWe),
    .wordIdx (busAddr[ADDR_W-1:2]),
    .strb    (strb)
  );

  ser_dp #(.DEPTH(FIFO_DEPTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .rxByte  (rxByte),
    .rxValid (rxValid),
    .rxReady (rxReady),
    .txByte  (txByte),
    .txValid (txValid),
    .irq     (irq),
    .rxCount (rxCount),
    .maskOut (maskQ)
  );
endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWe,
  input logic [5:0]       busAddr,
  input logic [31:0]      busWdata,
  input logic [31:0]      busRdata,
  input logic             rxValid,
  input logic             rxReady,
  input logic [7:0]       txByte,
  input logic             txValid,
  input logic             irq,
  input logic [CNT_W-1:0] rxCount,
  input logic [31:0]      maskQ
);
  logic wrDout, rdPeek, rdPop, pushing;
  assign wrDout  = busSel && busWe && (busAddr[5:2] == 4'h7);
  assign rdPeek  = busSel && !busWe && (busAddr[5:2] == 4'h9);
  assign rdPop   = busSel && !busWe && (busAddr[5:2] == 4'h8);
  assign pushing = rxValid && rxReady;

  a_r7_tx_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrDout |=> (txValid && txByte == $past(busWdata[7:0])));
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !wrDout |=> !txValid);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == CNT_W'(DEPTH)) |-> !rxReady);
  a_r3_peek_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rdPeek && !pushing) |=> $stable(rxCount));
  a_r3_pop_removes: assert property (@(posedge clk) disable iff (!rstN)
    (rdPop && rxCount != '0 && !pushing) |=> (rxCount == CNT_W'($past(rxCount) - 1'b1)));
  a_r2_tx_status: assert property (@(posedge clk) disable iff (!rstN)
    (rdPeek || rdPop) |-> (busRdata[24] && busRdata[22]));
  a_r9_irq_rx: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount != '0 && maskQ[3]) |-> irq);
endmodule

bind ser_port ser_port_chk #(.DEPTH(FIFO_DEPTH)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .rxValid  (rxValid),
  .rxReady  (rxReady),
  .txByte   (txByte),
  .txValid  (txValid),
  .irq      (irq),
  .rxCount  (rxCount),
  .maskQ    (maskQ)
);

// File: tb/sim_ser_port.sv
`timescale 1ns/1ps
module sim_ser_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  rxByte = '0;
  logic        rxValid = 1'b0;
  logic        rxReady;
  logic [7:0]  txByte;
  logic        txValid;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  localparam logic [31:0] ST_BASE = 32'h0140_0000;
  localparam logic [31:0] ST_DAV  = 32'h0001_0000;

  always #10 clk = ~clk;

  ser_port u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxByte(rxByte), .rxValid(rxValid),
    .rxReady(rxReady), .txByte(txByte), .txValid(txValid), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #2 d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rxReady", {31'b0, rxReady}, 32'h0);
    check("R1 txValid", {31'b0, txValid}, 32'h0);
    readCheck("R1 rxctrl", 6'h08, 32'h0001_0000);
    readCheck("R1 txctrl", 6'h00, 32'h0);
    readCheck("R1 mask", 6'h2C, 32'h0);
    readCheck("R1 raw", 6'h34, 32'h0);
    readCheck("R1 ack", 6'h30, 32'h0);
  endtask

  task automatic t_rx_disabled;
    logic [31:0] d;
    pushByte(8'h55);
    busRead(6'h24, d);
    check("R5 disabled discard", d & 32'hFFFF_FF00, ST_BASE);
    readCheck("R5 raw empty", 6'h34, 32'h0);
  endtask

  task automatic t_enable;
    busWrite(6'h08, 32'h8);
    @(negedge clk);
    check("R5 ready after enable", {31'b0, rxReady}, 32'h1);
  endtask

  task automatic t_peek_pop;
    logic [31:0] d;
    pushByte(8'h11);
    pushByte(8'h22);
    readCheck("R2 peek first", 6'h24, ST_BASE | ST_DAV | 32'h11);
    readCheck("R3 peek again", 6'h24, ST_BASE | ST_DAV | 32'h11);
    readCheck("R3 pop first", 6'h20, ST_BASE | ST_DAV | 32'h11);
    readCheck("R3 peek second", 6'h24, ST_BASE | ST_DAV | 32'h22);
    readCheck("R3 pop second", 6'h20, ST_BASE | ST_DAV | 32'h22);
    busRead(6'h20, d);
    check("R3 pop empty", d & 32'hFFFF_FF00, ST_BASE);
    busRead(6'h24, d);
    check("R3 still empty", d & 32'hFFFF_FF00, ST_BASE);
    readCheck("R6 raw clear", 6'h34, 32'h0);
  endtask

  task automatic t_fill;
    logic [31:0] d;
    for (int i = 0; i < 16; i++) pushByte(8'hA0 + 8'(i));
    @(negedge clk);
    check("R5 full not ready", {31'b0, rxReady}, 32'h0);
    pushByte(8'hEE);
    for (int i = 0; i < 16; i++)
      readCheck("R4 fifo order", 6'h20, ST_BASE | ST_DAV | {24'b0, 8'hA0 + 8'(i)});
    busRead(6'h20, d);
    check("R4 drained", d & 32'hFFFF_FF00, ST_BASE);
    @(negedge clk);
    check("R5 ready after drain", {31'b0, rxReady}, 32'h1);
  endtask

  task automatic t_raw_rx;
    logic [31:0] d;
    busWrite(6'h2C, 32'h8);
    pushByte(8'h33);
    readCheck("R6 raw set", 6'h34, 32'h8);
    readCheck("R9 masked rx", 6'h38, 32'h8);
    check("R9 irq rx", {31'b0, irq}, 32'h1);
    busWrite(6'h30, 32'h8);
    readCheck("R6 ack no clear", 6'h34, 32'h8);
    busRead(6'h20, d);
    @(negedge clk);
    check("R9 irq drop", {31'b0, irq}, 32'h0);
    readCheck("R6 raw empty", 6'h34, 32'h0);
  endtask

  task automatic t_tx;
    busWrite(6'h2C, 32'h1);
    busWrite(6'h1C, 32'h1234_5678);
    @(negedge clk);
    check("R7 txValid", {31'b0, txValid}, 32'h1);
    check("R7 txByte", {24'b0, txByte}, 32'h78);
    @(negedge clk);
    check("R7 single strobe", {31'b0, txValid}, 32'h0);
    readCheck("R7 dout readback", 6'h1C, 32'h1234_5678);
    readCheck("R7 raw tx bits", 6'h34, 32'h3);
    check("R9 irq tx", {31'b0, irq}, 32'h1);
    busWrite(6'h30, 32'h3);
    readCheck("R8 ack adjusted", 6'h30, 32'h2);
    readCheck("R8 raw after first ack", 6'h34, 32'h1);
    readCheck("R9 masked tx", 6'h38, 32'h1);
    check("R8 irq held", {31'b0, irq}, 32'h1);
    busWrite(6'h30, 32'h1);
    readCheck("R8 ack plain", 6'h30, 32'h1);
    readCheck("R8 raw cleared", 6'h34, 32'h0);
    check("R8 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    busWrite(6'h2C, 32'hF);
    pushByte(8'h44);
    busWrite(6'h20, 32'hFFFF_FFFF);
    busWrite(6'h24, 32'hFFFF_FFFF);
    busWrite(6'h34, 32'hFFFF_FFFF);
    busWrite(6'h38, 32'hFFFF_FFFF);
    readCheck("R10 write pop no effect", 6'h24, ST_BASE | ST_DAV | 32'h44);
    readCheck("R10 raw unchanged", 6'h34, 32'h8);
    readCheck("R10 masked unchanged", 6'h38, 32'h8);
    busRead(6'h20, d);
    busWrite(6'h00, 32'hDEAD_BEEF);
    busWrite(6'h04, 32'h0000_0001);
    readCheck("R10 txctrl store", 6'h00, 32'hDEAD_BEEF);
    readCheck("R10 dma store", 6'h04, 32'h0000_0001);
    busWrite(6'h0C, 32'h1234_5678);
    readCheck("R10 undecoded 0C", 6'h0C, 32'h0);
    readCheck("R10 undecoded 28", 6'h28, 32'h0);
    readCheck("R10 undecoded 3C", 6'h3C, 32'h0);
  endtask

  task automatic finishRun;
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_disabled();
    t_enable();
    t_peek_pop();
    t_fill();
    t_raw_rx();
    t_tx();
    t_ignored();
    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule